// File: doc/BRIEF.md
# Object-Table DMA Engine with CPU Bus Blocking

This block copies a 160-byte sprite attribute table from a CPU-visible source page into the object attribute memory (OAM), one byte at a time, on a fixed cadence. A transfer starts when the trigger strobe is high at a clock edge and carries a 16-bit source base. The engine then issues one source read and one OAM write per byte. The source read data returns in the same cycle, and the OAM write carries that data.

While a copy is in flight, the engine shields the bus from the CPU. CPU reads and writes to OAM are stopped, and so are CPU accesses to one further address window. That window depends on which 8 KiB region the current source address lies in, and on whether the system runs as the monochrome or the colour model. A blocked read returns 0xFF and drives no memory read strobe. A blocked write reaches no memory. All other accesses pass straight to the memory side. The engine's own source reads never go through this check.

Top module: `oam_dma_engine`

## Requirements
- R1: A trigger whose base is greater than 0xF100 has no effect. No transfer starts, and a transfer already running carries on unchanged. A base of exactly 0xF100 is accepted.
- R2: A transfer moves 160 bytes. Byte k (k = 0..159) is read from source address base+k and written to OAM offset k with the data returned by the source.
- R3: The trigger edge counts as edge 0. Byte 0 is written at clock edge 8 after the trigger edge, and each later byte is written 4 edges after the one before it. The source read and OAM write strobes are high for exactly the cycle before the write edge.
- R4: While a transfer is active, CPU accesses to 0xFE00-0xFE9F are blocked.
- R5: In monochrome mode (model_color_i = 0), the blocked window is chosen by bits 15:13 of the current source address. Value 4 blocks 0x8000-0x9FFF. Every other value blocks 0xA000-0xFDFF.
- R6: In colour mode (model_color_i = 1), the blocked window is chosen by bits 15:13 of the current source address. Value 4 blocks 0x8000-0x9FFF. Value 6 blocks 0xC000-0xFDFF. Every other value blocks 0xA000-0xBFFF.
- R7: A blocked access raises cpu_blocked_o, returns 0xFF on cpu_rdata_o, and holds mem_rd_o and mem_wr_o low. An access outside the blocked area forwards the strobes unchanged and returns mem_rdata_i.
- R8: After the edge that writes byte 159, and after reset, the engine is idle and every CPU access passes through.
- R9: The engine's source reads are issued even when the source address lies inside a blocked window.
- R10: An accepted trigger during an active transfer restarts the copy from the new base at byte 0, with the 8-edge first delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start strobe, sampled at the clock edge |
| trig_base_i | input | 16 | Source base for the transfer |
| model_color_i | input | 1 | 0 selects the monochrome window table, 1 selects the colour table |
| cpu_addr_i | input | 16 | CPU address |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Read data to the CPU, 0xFF when blocked |
| cpu_blocked_o | output | 1 | CPU address lies in the blocked area |
| mem_addr_o | output | 16 | Address to the memory side |
| mem_rd_o | output | 1 | Gated read strobe |
| mem_wr_o | output | 1 | Gated write strobe |
| mem_wdata_o | output | 8 | Write data to the memory side |
| mem_rdata_i | input | 8 | Read data from the memory side |
| src_req_o | output | 1 | Engine source read request |
| src_addr_o | output | 16 | Engine source address |
| src_rdata_i | input | 8 | Source read data, same cycle |
| oam_we_o | output | 1 | OAM write enable |
| oam_addr_o | output | 8 | OAM byte offset |
| oam_wdata_o | output | 8 | OAM write data |

## Verification
The bench counts clock edges from the last accepted trigger. It expects the source read and OAM write strobes only in the cycle before edges 8, 12, 16 and so on, up to the write of byte 159 at edge 644. It samples every output at the falling edge, one half cycle after the edge that changed the engine state. The CPU gating paths are combinational, so each cycle's random CPU access is applied at the falling edge and checked within that same half cycle. The blocked window is taken from the source address of the byte due next. Retriggers reset the bench's edge count, and ignored triggers leave it running.

// File: rtl/oam_dma_pkg.sv
package oam_dma_pkg;

  typedef struct packed {
    logic [15:0] lo;  // inclusive
    logic [15:0] hi;  // exclusive
  } win_t;

  // Blocked window selected by source region and model.
  function automatic win_t block_window(input logic color, input logic [2:0] region);
    win_t w;
    if (region == 3'd4) begin
      w.lo = 16'h8000; w.hi = 16'hA000;
    end else if (!color) begin
      w.lo = 16'hA000; w.hi = 16'hFE00;
    end else if (region == 3'd6) begin
      w.lo = 16'hC000; w.hi = 16'hFE00;
    end else begin
      w.lo = 16'hA000; w.hi = 16'hC000;
    end
    return w;
  endfunction

endpackage

// File: rtl/oam_dma_seq.sv
module oam_dma_seq #(
  parameter int          N_BYTES   = 160,
  parameter int          FIRST_GAP = 8,
  parameter int          NEXT_GAP  = 4,
  parameter logic [15:0] MAX_BASE  = 16'hF100,
  localparam int         IDX_W     = $clog2(N_BYTES),
  localparam int         CNT_W     = $clog2(FIRST_GAP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [15:0]      trig_base_i,
  output logic             active_o,
  output logic             fire_o,
  output logic [15:0]      src_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [CNT_W-1:0] FIRST_LD = CNT_W'(FIRST_GAP - 1);
  localparam logic [CNT_W-1:0] NEXT_LD  = CNT_W'(NEXT_GAP - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BYTES - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [15:0]      src_q;
  logic             accept, fire, last;

  assign accept = trig_i && (trig_base_i <= MAX_BASE);
  assign fire   = active_q && (cnt_q == '0);
  assign last   = (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
      src_q    <= '0;
    end else if (accept) begin
      // restart wins over an in-flight byte
      active_q <= 1'b1;
      cnt_q    <= FIRST_LD;
      idx_q    <= '0;
      src_q    <= trig_base_i;
    end else if (fire) begin
      if (last) begin
        active_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
        src_q <= src_q + 16'd1;
        cnt_q <= NEXT_LD;
      end
    end else if (active_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign fire_o   = fire;
  assign src_o    = src_q;
  assign idx_o    = idx_q;

  // R1
  ign_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && trig_base_i > MAX_BASE && !active_q) |=> !active_q);

  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (active_q && idx_q == '0 && src_q == $past(trig_base_i) && !fire));

  // R3
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !fire);

  // R8
  done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && last && !accept) |=> !active_q);

  // R2
  src_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !last && !accept) |=> (src_q == $past(src_q) + 16'd1));

endmodule

// File: rtl/oam_dma_guard.sv
module oam_dma_guard
  import oam_dma_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        active_i,
  input  logic        model_color_i,
  input  logic [15:0] src_i,
  input  logic [15:0] cpu_addr_i,
  input  logic        cpu_rd_i,
  input  logic        cpu_wr_i,
  input  logic [7:0]  mem_rdata_i,
  output logic        blocked_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic [7:0]  cpu_rdata_o
);

  localparam logic [15:0] OAM_LO = 16'hFE00;
  localparam logic [15:0] OAM_HI = 16'hFEA0;

  win_t win;
  logic in_oam, in_win, blocked;

  assign win     = block_window(model_color_i, src_i[15:13]);
  assign in_oam  = (cpu_addr_i >= OAM_LO) && (cpu_addr_i < OAM_HI);
  assign in_win  = (cpu_addr_i >= win.lo) && (cpu_addr_i < win.hi);
  assign blocked = active_i && (in_oam || in_win);

  assign blocked_o   = blocked;
  assign mem_rd_o    = cpu_rd_i && !blocked;
  assign mem_wr_o    = cpu_wr_i && !blocked;
  assign cpu_rdata_o = blocked ? 8'hFF : mem_rdata_i;

  // R4
  oam_blk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cpu_rd_i && cpu_addr_i >= 16'hFE00 && cpu_addr_i <= 16'hFE9F)
      |-> (cpu_rdata_o == 8'hFF && !mem_rd_o));

  // R7
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_o |-> (!mem_rd_o && !mem_wr_o));

  // R8
  idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (mem_rd_o == cpu_rd_i && mem_wr_o == cpu_wr_i && cpu_rdata_o == mem_rdata_i));

endmodule

// File: rtl/oam_dma_engine.sv
module oam_dma_engine #(
  parameter int          N_BYTES   = 160,
  parameter int          FIRST_GAP = 8,
  parameter int          NEXT_GAP  = 4,
  parameter logic [15:0] MAX_BASE  = 16'hF100,
  localparam int         IDX_W     = $clog2(N_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [15:0]      trig_base_i,
  input  logic             model_color_i,
  input  logic [15:0]      cpu_addr_i,
  input  logic             cpu_rd_i,
  input  logic             cpu_wr_i,
  input  logic [7:0]       cpu_wdata_i,
  output logic [7:0]       cpu_rdata_o,
  output logic             cpu_blocked_o,
  output logic [15:0]      mem_addr_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic [7:0]       mem_wdata_o,
  input  logic [7:0]       mem_rdata_i,
  output logic             src_req_o,
  output logic [15:0]      src_addr_o,
  input  logic [7:0]       src_rdata_i,
  output logic             oam_we_o,
  output logic [IDX_W-1:0] oam_addr_o,
  output logic [7:0]       oam_wdata_o
);

  logic             active, fire;
  logic [15:0]      src;
  logic [IDX_W-1:0] idx;

  oam_dma_seq #(
    .N_BYTES  (N_BYTES),
    .FIRST_GAP(FIRST_GAP),
    .NEXT_GAP (NEXT_GAP),
    .MAX_BASE (MAX_BASE)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .trig_base_i(trig_base_i),
    .active_o   (active),
    .fire_o     (fire),
    .src_o      (src),
    .idx_o      (idx)
  );

  oam_dma_guard u_guard (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (active),
    .model_color_i(model_color_i),
    .src_i        (src),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_rd_i     (cpu_rd_i),
    .cpu_wr_i     (cpu_wr_i),
    .mem_rdata_i  (mem_rdata_i),
    .blocked_o    (cpu_blocked_o),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .cpu_rdata_o  (cpu_rdata_o)
  );

  assign mem_addr_o  = cpu_addr_i;
  assign mem_wdata_o = cpu_wdata_i;

  // R9: engine reads take a private path, never gated
  assign src_req_o   = fire;
  assign src_addr_o  = src;
  assign oam_we_o    = fire;
  assign oam_addr_o  = idx;
  assign oam_wdata_o = src_rdata_i;

endmodule

// File: tb/oam_dma_engine_tb.sv
module oam_dma_engine_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trig_i = 1'b0;
  logic [15:0] trig_base_i = '0;
  logic        model_color_i = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic        cpu_rd_i = 1'b0, cpu_wr_i = 1'b0;
  logic [7:0]  cpu_wdata_i = '0;
  logic [7:0]  cpu_rdata_o;
  logic        cpu_blocked_o;
  logic [15:0] mem_addr_o;
  logic        mem_rd_o, mem_wr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        src_req_o;
  logic [15:0] src_addr_o;
  logic [7:0]  src_rdata_i;
  logic        oam_we_o;
  logic [7:0]  oam_addr_o;
  logic [7:0]  oam_wdata_o;

  int n_chk = 0, n_fail = 0;

  // model state
  logic        m_act = 1'b0;
  int          m_d = 0;
  logic [15:0] m_base = '0;

  always #2.5 clk = ~clk;  // 200 MHz

  function automatic logic [7:0] src_pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign src_rdata_i = src_pat(src_addr_o);

  oam_dma_engine u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .trig_i(trig_i), .trig_base_i(trig_base_i),
    .model_color_i(model_color_i), .cpu_addr_i(cpu_addr_i), .cpu_rd_i(cpu_rd_i),
    .cpu_wr_i(cpu_wr_i), .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
    .cpu_blocked_o(cpu_blocked_o), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .src_req_o(src_req_o), .src_addr_o(src_addr_o), .src_rdata_i(src_rdata_i),
    .oam_we_o(oam_we_o), .oam_addr_o(oam_addr_o), .oam_wdata_o(oam_wdata_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // window from the requirement tables
  function automatic logic in_window(input logic color, input logic [15:0] s, input logic [15:0] a);
    int r;
    r = int'(s[15:13]);
    if (r == 4) return (a >= 16'h8000 && a <= 16'h9FFF);
    if (!color) return (a >= 16'hA000 && a <= 16'hFDFF);
    if (r == 6) return (a >= 16'hC000 && a <= 16'hFDFF);
    return (a >= 16'hA000 && a <= 16'hBFFF);
  endfunction

  task automatic step(input logic t, input logic [15:0] b);
    logic exp_fire, in_oam, in_w, exp_blk;
    logic [15:0] es;
    int k;
    string tag;
    @(negedge clk);
    trig_i = t;
    trig_base_i = b;
    cpu_addr_i = ($urandom_range(3) == 0) ? 16'(16'hFE00 + $urandom_range(16'hBF))
                                          : 16'($urandom);
    cpu_rd_i = 1'($urandom);
    cpu_wr_i = !cpu_rd_i && 1'($urandom);
    cpu_wdata_i = 8'($urandom);
    mem_rdata_i = 8'($urandom);
    #1;
    k = (m_d < 8) ? 0 : ((m_d - 8) / 4 + 1);
    exp_fire = m_act && m_d >= 7 && ((m_d - 7) % 4 == 0) && k < 160;
    es = m_base + 16'(k);
    // R3 cadence, R9 source read issued regardless of blocking
    chk(oam_we_o == exp_fire, "R3 oam_we", int'(oam_we_o), int'(exp_fire));
    chk(src_req_o == exp_fire, "R9 src_req", int'(src_req_o), int'(exp_fire));
    if (exp_fire) begin
      chk(src_addr_o == es, "R2 src_addr", int'(src_addr_o), int'(es));
      chk(oam_addr_o == 8'(k), "R2 oam_addr", int'(oam_addr_o), k);
      chk(oam_wdata_o == src_pat(es), "R2 oam_wdata", int'(oam_wdata_o), int'(src_pat(es)));
    end
    in_oam = cpu_addr_i >= 16'hFE00 && cpu_addr_i <= 16'hFE9F;
    in_w = in_window(model_color_i, es, cpu_addr_i);
    exp_blk = m_act && (in_oam || in_w);
    if (!m_act) tag = "R8 idle";
    else if (in_oam) tag = "R4 oam";
    else if (in_w) tag = model_color_i ? "R6 colour window" : "R5 mono window";
    else tag = "R7 pass";
    chk(cpu_blocked_o == exp_blk, {tag, " blocked"}, int'(cpu_blocked_o), int'(exp_blk));
    chk(mem_rd_o == (cpu_rd_i && !exp_blk), {tag, " mem_rd"}, int'(mem_rd_o), int'(cpu_rd_i && !exp_blk));
    chk(mem_wr_o == (cpu_wr_i && !exp_blk), {tag, " mem_wr"}, int'(mem_wr_o), int'(cpu_wr_i && !exp_blk));
    if (cpu_rd_i)
      chk(cpu_rdata_o == (exp_blk ? 8'hFF : mem_rdata_i), {tag, " rdata R7"},
          int'(cpu_rdata_o), int'(exp_blk ? 8'hFF : mem_rdata_i));
    // model update for the coming edge
    if (t && b <= 16'hF100) begin
      m_act = 1'b1; m_d = 0; m_base = b;
    end else if (m_act) begin
      if (exp_fire && k == 159) m_act = 1'b0;
      else m_d++;
    end
  endtask

  task automatic transfer(input logic color, input logic [15:0] b, input int tail);
    model_color_i = color;
    step(1'b1, b);
    repeat (644 + tail) step(1'b0, 16'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R8 reset state
    repeat (10) step(1'b0, 16'h0);
    // R1 over-limit trigger while idle
    step(1'b1, 16'hF101);
    repeat (30) step(1'b0, 16'h0);
    // R5 monochrome regions
    transfer(1'b0, 16'h8000, 4);
    transfer(1'b0, 16'hC000, 4);
    // R6 colour regions, including the accepted limit 0xF100
    transfer(1'b1, 16'hC000, 4);
    transfer(1'b1, 16'h8000, 4);
    transfer(1'b1, 16'h0100, 4);
    transfer(1'b1, 16'hF100, 4);
    // R10 restart mid-transfer
    model_color_i = 1'b0;
    step(1'b1, 16'h4000);
    repeat (101) step(1'b0, 16'h0);
    step(1'b1, 16'hD000);
    repeat (50) step(1'b0, 16'h0);
    // R1 over-limit trigger mid-transfer is ignored
    step(1'b1, 16'hFFFF);
    repeat (620) step(1'b0, 16'h0);
    // random bases and models
    for (int i = 0; i < 4; i++) begin
      transfer(1'($urandom), 16'($urandom_range(16'hF100)), 6);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule